// File: doc/BRIEF.md
# Fetch Address Sequencer with Delayed Jumps

This block owns the fetch address of a word-aligned instruction fetch stage. Each cycle it presents the current fetch address, receives the 32-bit instruction word fetched from that address, and also receives the value of the source register named by that word. When there is no pending redirect, it advances the address by one word.

Two unconditional jump forms are recognised. The region jump keeps the top address bits of the instruction after the jump and replaces the rest with a word index taken from the instruction. The register jump takes a full address from the register value. Either jump takes effect one instruction late. The word right after the jump (the delay slot) is always fetched before the target.

A jump found inside a delay slot has no defined meaning. The block raises a one-cycle flag for it and discards that second jump.

Top module: `fetch_pc_seq`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the fetch address loads 0x00400000 and the slot flag is driven low.
- R2: With no redirect pending, the fetch address advances by 4 on every clock.
- R3: A word whose bits 31:26 equal 000010 is a region jump. Its target is bits 31:28 of the delay-slot address (the jump address plus 4), followed by bits 25:0 of the word, followed by two zero bits.
- R4: A word whose bits 31:26 equal 000000 and whose bits 5:0 equal 001000 is a register jump. Its target is the register value input with its two low bits forced to zero.
- R5: After a jump fetched at address A, the next fetch address is A+4 (the delay slot). The one after that is the jump target.
- R6: A jump decoded while fetching a delay slot raises the slot flag for exactly the following cycle. That second jump is discarded: the first target is still taken, and sequential fetch follows it.
- R7: Any other encoding is not a jump, including bits 31:26 of 000011, bits 31:26 of 000001 with bits 5:0 of 001000, and bits 31:26 of 000000 with bits 5:0 of 001001. Such words cause a plain advance by 4.
- R8: The fetch address always has its two low bits at zero.
- R9: A reset that arrives while a target is pending cancels that target. After the reset, fetch proceeds sequentially from 0x00400000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word fetched from the current fetch address |
| reg_val_i | input | 32 | Value of the register used by a register jump |
| fetch_addr_o | output | 32 | Registered fetch address |
| slot_jump_o | output | 1 | Registered flag: the previous delay slot held a jump |

## Verification
In the delay-slot cycle, the redirect to the pending target and the decode of a new jump fall on the same clock edge. The bench provokes this by placing a register jump directly after a region jump. It then judges that the fetch address lands on the first target with the flag raised, and that the next address is that target plus 4 with the flag dropped. A reset that lands in the same cycle as a pending redirect is provoked as well. The bench judges it by the post-reset sequence not reaching the cancelled target.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned INSN_W   = 32;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned FUNCT_W  = 6;
  localparam int unsigned OPC_LSB  = INSN_W - OPC_W;

  localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'b000000;
  localparam logic [OPC_W-1:0]   OPC_REGION  = 6'b000010;
  localparam logic [FUNCT_W-1:0] FN_REGJUMP  = 6'b001000;

  typedef enum logic [1:0] {
    JK_NONE     = 2'd0,
    JK_REGION   = 2'd1,
    JK_REGISTER = 2'd2
  } jump_kind_e;
endpackage

// File: rtl/fpc_jump_decode.sv
module fpc_jump_decode
  import fpc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned REGION_W = 4,
  parameter int unsigned ALIGN_W  = 2
) (
  input  logic [INSN_W-1:0] insn_i,
  input  logic [ADDR_W-1:0] slot_addr_i,
  input  logic [ADDR_W-1:0] reg_val_i,
  output jump_kind_e        kind_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned FIELD_W = ADDR_W - REGION_W - ALIGN_W;
  localparam logic [ADDR_W-1:0] LOW_MASK    = ADDR_W'((64'd1 << (ADDR_W - REGION_W)) - 64'd1);
  localparam logic [ADDR_W-1:0] REGION_MASK = ~LOW_MASK;
  localparam logic [ADDR_W-1:0] ALIGN_MASK  = ~ADDR_W'((64'd1 << ALIGN_W) - 64'd1);

  logic [OPC_W-1:0]   opc;
  logic [FUNCT_W-1:0] fn;
  logic [ADDR_W-1:0]  region_tgt;
  logic [ADDR_W-1:0]  reg_tgt;

  assign opc = insn_i[INSN_W-1:OPC_LSB];
  assign fn  = insn_i[FUNCT_W-1:0];

  assign region_tgt = (slot_addr_i & REGION_MASK)
                    | ADDR_W'({insn_i[FIELD_W-1:0], {ALIGN_W{1'b0}}});
  assign reg_tgt    = reg_val_i & ALIGN_MASK;

  always_comb begin
    kind_o   = JK_NONE;
    target_o = reg_tgt;
    if (opc == OPC_REGION) begin
      kind_o   = JK_REGION;
      target_o = region_tgt;
    end else if (opc == OPC_SPECIAL && fn == FN_REGJUMP) begin
      kind_o   = JK_REGISTER;
      target_o = reg_tgt;
    end
  end

  // R4
  always_comb begin
    regjump_aligned_chk: assert (kind_o != JK_REGISTER || target_o[ALIGN_W-1:0] == '0)
      else $error("register jump target not aligned");
  end
endmodule

// File: rtl/fpc_pending.sv
module fpc_pending #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] target_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] target_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      target_q <= '0;
    end else if (valid_q) begin
      valid_q  <= 1'b0;
    end else if (load_i) begin
      valid_q  <= 1'b1;
      target_q <= target_i;
    end
  end

  assign valid_o  = valid_q;
  assign target_o = target_q;

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !valid_q) |=> (valid_q && target_q == $past(target_i)))
    else $error("pending target not captured");

  // R6
  single_use_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q)
    else $error("pending target held beyond one slot");
endmodule

// File: rtl/fpc_pc_reg.sv
module fpc_pc_reg #(
  parameter int unsigned        ADDR_W     = 32,
  parameter int unsigned        STEP_BYTES = 4,
  parameter int unsigned        ALIGN_W    = 2,
  parameter logic [ADDR_W-1:0]  RESET_PC   = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_addr_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP_BYTES);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    pc_d = pc_q + STEP_V;
    if (redirect_i) pc_d = redirect_addr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R1
  reset_value_chk: assert property (@(posedge clk)
    rst |=> pc_q == RESET_PC)
    else $error("fetch address not at reset value");

  // R8
  aligned_chk: assert property (@(posedge clk) disable iff (rst)
    pc_q[ALIGN_W-1:0] == '0)
    else $error("fetch address misaligned");
endmodule

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq
  import fpc_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       REGION_W   = 4,
  parameter int unsigned       STEP_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC   = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instr_i,
  input  logic [ADDR_W-1:0] reg_val_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              slot_jump_o
);
  localparam int unsigned ALIGN_W = $clog2(STEP_BYTES);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP_BYTES);

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] slot_addr;
  jump_kind_e        kind;
  logic [ADDR_W-1:0] tgt;
  logic              is_jump;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_target;
  logic              flag_q;

  assign slot_addr = pc + STEP_V;
  assign is_jump   = (kind != JK_NONE);

  fpc_jump_decode #(
    .ADDR_W   (ADDR_W),
    .REGION_W (REGION_W),
    .ALIGN_W  (ALIGN_W)
  ) decode_i (
    .insn_i      (instr_i),
    .slot_addr_i (slot_addr),
    .reg_val_i   (reg_val_i),
    .kind_o      (kind),
    .target_o    (tgt)
  );

  fpc_pending #(
    .ADDR_W (ADDR_W)
  ) pending_i (
    .clk      (clk),
    .rst      (rst),
    .load_i   (is_jump && !pend_valid),
    .target_i (tgt),
    .valid_o  (pend_valid),
    .target_o (pend_target)
  );

  fpc_pc_reg #(
    .ADDR_W     (ADDR_W),
    .STEP_BYTES (STEP_BYTES),
    .ALIGN_W    (ALIGN_W),
    .RESET_PC   (RESET_PC)
  ) pc_reg_i (
    .clk             (clk),
    .rst             (rst),
    .redirect_i      (pend_valid),
    .redirect_addr_i (pend_target),
    .pc_o            (pc)
  );

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= pend_valid && is_jump;
  end

  assign fetch_addr_o = pc;
  assign slot_jump_o  = flag_q;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_valid |=> fetch_addr_o == $past(fetch_addr_o) + STEP_V)
    else $error("sequential step wrong");

  // R5
  slot_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    pend_valid |=> fetch_addr_o == $past(pend_target))
    else $error("delay-slot redirect missed");

  // R6
  slot_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && is_jump) |=> slot_jump_o)
    else $error("jump in slot not flagged");

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_valid |=> !slot_jump_o)
    else $error("slot flag raised outside a slot");
endmodule

// File: tb/fetch_pc_seq_tb_top.sv
module fetch_pc_seq_tb_top;
  localparam logic [31:0] RESET_PC = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_i = '0;
  logic [31:0] reg_val_i = '0;
  logic [31:0] fetch_addr_o;
  logic        slot_jump_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] q_pc[$];
  logic        q_flag[$];
  string       q_tag[$];

  logic [31:0] m_pc    = RESET_PC;
  logic        m_valid = 1'b0;
  logic [31:0] m_tgt   = '0;

  always #4 clk = ~clk;

  fetch_pc_seq dut_i (
    .clk          (clk),
    .rst          (rst),
    .instr_i      (instr_i),
    .reg_val_i    (reg_val_i),
    .fetch_addr_o (fetch_addr_o),
    .slot_jump_o  (slot_jump_o)
  );

  function automatic int kind_of(input logic [31:0] w);
    if (w[31:26] == 6'b000010) return 1;
    if (w[31:26] == 6'b000000 && w[5:0] == 6'b001000) return 2;
    return 0;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic step(input logic [31:0] w, input logic [31:0] rv, input string tag);
    logic [31:0] npc;
    logic        nflag;
    logic [31:0] slot;
    int          k;
    @(negedge clk);
    rst       = 1'b0;
    instr_i   = w;
    reg_val_i = rv;
    k    = kind_of(w);
    slot = m_pc + 32'd4;
    if (m_valid) begin
      npc     = m_tgt;
      nflag   = (k != 0);
      m_valid = 1'b0;
    end else begin
      npc   = slot;
      nflag = 1'b0;
      if (k == 1) begin
        m_valid = 1'b1;
        m_tgt   = {slot[31:28], w[25:0], 2'b00};
      end else if (k == 2) begin
        m_valid = 1'b1;
        m_tgt   = {rv[31:2], 2'b00};
      end
    end
    m_pc = npc;
    q_pc.push_back(npc);
    q_flag.push_back(nflag);
    q_tag.push_back(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst     = 1'b1;
    instr_i = '0;
    m_pc    = RESET_PC;
    m_valid = 1'b0;
    q_pc.push_back(RESET_PC);
    q_flag.push_back(1'b0);
    q_tag.push_back(tag);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_pc.size() > 0) begin
        logic [31:0] e_pc;
        logic        e_flag;
        string       t;
        e_pc   = q_pc.pop_front();
        e_flag = q_flag.pop_front();
        t      = q_tag.pop_front();
        n_checks++;
        if (fetch_addr_o !== e_pc) begin
          n_fail++;
          $display("FAIL %s fetch_addr actual=%h expected=%h", t, fetch_addr_o, e_pc);
        end
        n_checks++;
        if (slot_jump_o !== e_flag) begin
          n_fail++;
          $display("FAIL %s slot_jump actual=%b expected=%b", t, slot_jump_o, e_flag);
        end
        n_checks++;
        if (fetch_addr_o[1:0] !== 2'b00) begin
          n_fail++;
          $display("FAIL R8 fetch_addr low bits actual=%b expected=00", fetch_addr_o[1:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset state");
    for (int i = 0; i < 4; i++) step(32'h0, 32'h0, "R2 sequential");
    // worked example: jump at 0x00400010
    step(32'h0810_0000, 32'h0, "R3 region jump slot");
    step(32'h0, 32'h0, "R5 region target after slot");
    step(32'h0, 32'h0, "R2 after redirect");
    // register jump
    step(32'h00A0_0008, 32'h0040_0104, "R4 register jump slot");
    step(32'h0, 32'h0, "R5 register target");
    // misaligned register value
    step(32'h00A0_0008, 32'h1FFF_FFFB, "R4 misaligned value");
    step(32'h0, 32'h0, "R4 low bits dropped");
    step(32'h0, 32'h0, "R2 to region edge");
    // region jump at last word of a region: slot is in next region
    step(32'h0800_0010, 32'h0, "R3 jump at region edge");
    step(32'h0, 32'h0, "R3 region taken from slot");
    // jump inside a delay slot
    step(32'h0800_0100, 32'h0, "R6 first jump");
    step(32'h00A0_0008, 32'h0000_1111, "R6 jump in slot");
    step(32'h0, 32'h0, "R6 second jump discarded");
    step(32'h0, 32'h0, "R6 flag dropped");
    // near-miss encodings
    step(32'h0C00_0100, 32'h0000_5000, "R7 opcode 000011");
    step(32'h00A0_0009, 32'h0000_5000, "R7 funct 001001");
    step(32'h04A0_0008, 32'h0000_5000, "R7 opcode 000001");
    step(32'h0, 32'h0, "R7 no late redirect");
    // reset while a target is pending
    step(32'h0810_0000, 32'h0, "R9 jump before reset");
    do_reset("R9 reset with pending");
    step(32'h0, 32'h0, "R9 pending cancelled");
    step(32'h0, 32'h0, "R9 sequential resumes");
    repeat (3) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule